// File: doc/BRIEF.md
# Prioritized Fetch Address Selector

This block owns the fetch program counter of an instruction front end. Each cycle it decides where the next fetch goes. The sources it weighs are an exception vector, three branch-mispredict corrections (from the execute, dispatch and decode stages), a hit in the branch target cache, and plain sequential advance. When several sources request a redirect in the same cycle, one fixed ranking picks the winner and the others are dropped for that cycle.

It also keeps count of how full the eight-slot instruction queue is. The cache may offer up to four instructions per fetch. The block takes only as many as the queue has room for, and advances the counter by four bytes per instruction taken. A recovery or exception empties the queue. The stage the recovery came from decides whether the instruction held in decode is also discarded. The cache, the target-cache contents and the decoder are outside the block and appear only as ports.

Top module: `fetch_addr_sel`

## Requirements
- R1: While reset is high, fetch_pc becomes RESET_VEC (default 0x100) and q_count becomes 0 at each clock edge.
- R2: The winner is ranked as follows, highest first: exception, execute recovery, dispatch recovery, decode recovery, target-cache hit, sequential. redirect_src reports the winner with these codes: 0 sequential, 1 exception, 2 execute, 3 dispatch, 4 decode, 5 target-cache hit.
- R3: An exception makes fetch_pc equal exc_vec after the next edge, and raises flush_queue and flush_decode in the request cycle.
- R4: A winning execute or dispatch recovery loads its target into fetch_pc and raises both flush_queue and flush_decode.
- R5: A winning decode recovery loads its target into fetch_pc and raises flush_queue with flush_decode low.
- R6: In any cycle with an exception or recovery, fetch_take is 0, so cache data is discarded. q_count is 0 after the edge, whatever deq_cnt is.
- R7: A target-cache hit with no higher request, and with every offered instruction accepted, loads btc_tgt into fetch_pc. It flushes nothing.
- R8: A target-cache hit is ignored (redirect_src 0) when the queue cannot accept all offered instructions or no fetch is valid. fetch_pc then advances sequentially.
- R9: Without a redirect, fetch_pc advances by 4 times fetch_take, and holds when fetch_take is 0.
- R10: fetch_take equals the smaller of the offered count (clamped to 4) and the free slots (8 minus q_count). It is 0 when icache_valid is low.
- R11: Without a flush, the next q_count is q_count minus the smaller of deq_cnt and q_count, plus fetch_take. It never exceeds 8.
- R12: Bits [1:0] of every loaded target are forced to zero, so fetch_pc stays word aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| exc_req | input | 1 | Exception redirect request |
| exc_vec | input | 32 | Exception vector address |
| mp_ex_req | input | 1 | Mispredict recovery from execute stage |
| mp_ex_tgt | input | 32 | Corrected target from execute stage |
| mp_dp_req | input | 1 | Mispredict recovery from dispatch stage |
| mp_dp_tgt | input | 32 | Corrected target from dispatch stage |
| mp_dc_req | input | 1 | Mispredict recovery from decode stage |
| mp_dc_tgt | input | 32 | Corrected target from decode stage |
| btc_hit | input | 1 | Branch target cache hit for the current fetch address |
| btc_tgt | input | 32 | Cached branch target |
| icache_valid | input | 1 | Cache returns instructions this cycle |
| icache_cnt | input | 3 | Instructions offered by the cache (values above 4 clamp to 4) |
| deq_cnt | input | 3 | Instructions removed from the queue by decode this cycle |
| fetch_pc | output | 32 | Current fetch address |
| fetch_take | output | 3 | Instructions written into the queue this cycle |
| q_count | output | 4 | Queue occupancy |
| flush_queue | output | 1 | Discard all queued instructions |
| flush_decode | output | 1 | Also discard the instruction held in decode |
| redirect_src | output | 3 | Winning address source code |

## Verification
The assertions assume the inputs are known, 2-state values after reset. They also assume deq_cnt may name more instructions than the queue holds, since the block clamps it. No assertion assumes a redirect request holds for more than one cycle. The stimulus drives every input at the falling edge with defined values, and exercises both the clamp on the offered count and the clamp on dequeue. It also includes targets with low bits set, to check the alignment forcing without breaking any of these assumptions.

// File: rtl/fetch_sel_pkg.sv
package fetch_sel_pkg;
    typedef enum logic [2:0] {
        SRC_SEQ = 3'd0,
        SRC_EXC = 3'd1,
        SRC_EXE = 3'd2,
        SRC_DSP = 3'd3,
        SRC_DEC = 3'd4,
        SRC_BTC = 3'd5
    } fetch_src_e;

    function automatic logic [31:0] word_align(input logic [31:0] a);
        return {a[31:2], 2'b00};
    endfunction
endpackage

// File: rtl/fetch_redirect_arb.sv
module fetch_redirect_arb
    import fetch_sel_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          exc_req,
    input  logic [AW-1:0] exc_vec,
    input  logic          mp_ex_req,
    input  logic [AW-1:0] mp_ex_tgt,
    input  logic          mp_dp_req,
    input  logic [AW-1:0] mp_dp_tgt,
    input  logic          mp_dc_req,
    input  logic [AW-1:0] mp_dc_tgt,
    input  logic          btc_hit,
    input  logic [AW-1:0] btc_tgt,
    input  logic          all_fit,
    output fetch_src_e    src,
    output logic          load,
    output logic [AW-1:0] load_addr,
    output logic          flush_q,
    output logic          flush_d
);
    typedef struct packed {
        fetch_src_e    src;
        logic          load;
        logic [AW-1:0] addr;
        logic          fq;
        logic          fd;
    } sel_t;

    sel_t sel_d;

    // Fixed ranking: the later a pipeline stage, the higher its recovery ranks
    always_comb begin
        sel_d = '{src: SRC_SEQ, load: 1'b0, addr: '0, fq: 1'b0, fd: 1'b0};
        if (exc_req) begin
            sel_d = '{src: SRC_EXC, load: 1'b1, addr: exc_vec, fq: 1'b1, fd: 1'b1};
        end else if (mp_ex_req) begin
            sel_d = '{src: SRC_EXE, load: 1'b1, addr: mp_ex_tgt, fq: 1'b1, fd: 1'b1};
        end else if (mp_dp_req) begin
            sel_d = '{src: SRC_DSP, load: 1'b1, addr: mp_dp_tgt, fq: 1'b1, fd: 1'b1};
        end else if (mp_dc_req) begin
            sel_d = '{src: SRC_DEC, load: 1'b1, addr: mp_dc_tgt, fq: 1'b1, fd: 1'b0};
        end else if (btc_hit && all_fit) begin
            sel_d = '{src: SRC_BTC, load: 1'b1, addr: btc_tgt, fq: 1'b0, fd: 1'b0};
        end
        sel_d.addr[1:0] = 2'b00;
    end

    assign src       = sel_d.src;
    assign load      = sel_d.load;
    assign load_addr = sel_d.addr;
    assign flush_q   = sel_d.fq;
    assign flush_d   = sel_d.fd;

    // R2
    exc_top_chk: assert property (@(posedge clk) disable iff (rst)
        exc_req |-> (src == SRC_EXC && flush_d && flush_q));
    // R5
    dec_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_DEC) |-> (flush_q && !flush_d && !exc_req && !mp_ex_req && !mp_dp_req));
    // R8
    btc_partial_chk: assert property (@(posedge clk) disable iff (rst)
        (btc_hit && !all_fit && !exc_req && !mp_ex_req && !mp_dp_req && !mp_dc_req)
        |-> (src == SRC_SEQ && !load));
    // R7
    btc_noflush_chk: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_BTC) |-> (!flush_q && !flush_d && btc_hit));
endmodule

// File: rtl/fetch_queue_acct.sv
module fetch_queue_acct #(
    parameter int FETCH_W = 4,
    parameter int Q_DEPTH = 8,
    localparam int CNT_W  = $clog2(FETCH_W + 1),
    localparam int QCNT_W = $clog2(Q_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              icache_valid,
    input  logic [CNT_W-1:0]  icache_cnt,
    input  logic [CNT_W-1:0]  deq_cnt,
    output logic [CNT_W-1:0]  take,
    output logic              all_fit,
    output logic [QCNT_W-1:0] count_q
);
    typedef struct packed {
        logic [QCNT_W-1:0] count;
    } qst_t;

    qst_t st_d, st_q;
    logic [QCNT_W-1:0] off_w, free_w, deq_w, fit_w;

    // Sizing depends only on state and cache inputs, never on flush
    always_comb begin
        off_w  = (icache_cnt > CNT_W'(FETCH_W)) ? QCNT_W'(FETCH_W) : QCNT_W'(icache_cnt);
        free_w = QCNT_W'(Q_DEPTH) - st_q.count;
    end

    assign all_fit = icache_valid && (off_w != '0) && (off_w <= free_w);

    always_comb begin
        st_d  = st_q;
        fit_w = '0;
        deq_w = (QCNT_W'(deq_cnt) > st_q.count) ? st_q.count : QCNT_W'(deq_cnt);
        if (flush) begin
            st_d.count = '0;
        end else begin
            if (icache_valid)
                fit_w = (off_w < free_w) ? off_w : free_w;
            st_d.count = st_q.count - deq_w + fit_w;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{count: '0};
        else     st_q <= st_d;
    end

    assign take    = CNT_W'(fit_w);
    assign count_q = st_q.count;

    // R11
    q_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count_q <= QCNT_W'(Q_DEPTH));
    // R6
    flush_clear_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count_q == '0));
    // R10
    take_fit_chk: assert property (@(posedge clk) disable iff (rst)
        (QCNT_W'(take) <= free_w) && (QCNT_W'(take) <= QCNT_W'(FETCH_W)));
    // R6
    flush_notake_chk: assert property (@(posedge clk) disable iff (rst)
        (flush || !icache_valid) |-> (take == '0));
endmodule

// File: rtl/fetch_pc_reg.sv
module fetch_pc_reg
    import fetch_sel_pkg::*;
#(
    parameter int          AW        = 32,
    parameter int          CNT_W     = 3,
    parameter logic [31:0] RESET_VEC = 32'h0000_0100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [AW-1:0]    load_addr,
    input  logic [CNT_W-1:0] take,
    output logic [AW-1:0]    pc_q
);
    typedef struct packed {
        logic [AW-1:0] pc;
    } pcst_t;

    pcst_t st_d, st_q;
    localparam logic [AW-1:0] RST_PC = {RESET_VEC[AW-1:2], 2'b00};

    always_comb begin
        st_d = st_q;
        if (load) st_d.pc = load_addr;
        else      st_d.pc = st_q.pc + AW'({take, 2'b00});
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '{pc: RST_PC};
        else     st_q <= st_d;
    end

    assign pc_q = st_q.pc;

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && take == '0) |=> $stable(pc_q));
    // R3
    load_follow_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (pc_q[AW-1:2] == $past(load_addr[AW-1:2])));
    // R12
    pc_align_chk: assert property (@(posedge clk) disable iff (rst)
        pc_q[1:0] == 2'b00);
endmodule

// File: rtl/fetch_addr_sel.sv
module fetch_addr_sel
    import fetch_sel_pkg::*;
#(
    parameter int          FETCH_W   = 4,
    parameter int          Q_DEPTH   = 8,
    parameter logic [31:0] RESET_VEC = 32'h0000_0100,
    localparam int         AW        = 32,
    localparam int         CNT_W     = $clog2(FETCH_W + 1),
    localparam int         QCNT_W    = $clog2(Q_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              exc_req,
    input  logic [AW-1:0]     exc_vec,
    input  logic              mp_ex_req,
    input  logic [AW-1:0]     mp_ex_tgt,
    input  logic              mp_dp_req,
    input  logic [AW-1:0]     mp_dp_tgt,
    input  logic              mp_dc_req,
    input  logic [AW-1:0]     mp_dc_tgt,
    input  logic              btc_hit,
    input  logic [AW-1:0]     btc_tgt,
    input  logic              icache_valid,
    input  logic [CNT_W-1:0]  icache_cnt,
    input  logic [CNT_W-1:0]  deq_cnt,
    output logic [AW-1:0]     fetch_pc,
    output logic [CNT_W-1:0]  fetch_take,
    output logic [QCNT_W-1:0] q_count,
    output logic              flush_queue,
    output logic              flush_decode,
    output logic [2:0]        redirect_src
);
    fetch_src_e        src_w;
    logic              load_w, fq_w, fd_w, all_fit_w;
    logic [AW-1:0]     addr_w;
    logic [CNT_W-1:0]  take_w;

    fetch_redirect_arb #(.AW(AW)) u_arb (
        .clk       (clk),
        .rst       (rst),
        .exc_req   (exc_req),
        .exc_vec   (exc_vec),
        .mp_ex_req (mp_ex_req),
        .mp_ex_tgt (mp_ex_tgt),
        .mp_dp_req (mp_dp_req),
        .mp_dp_tgt (mp_dp_tgt),
        .mp_dc_req (mp_dc_req),
        .mp_dc_tgt (mp_dc_tgt),
        .btc_hit   (btc_hit),
        .btc_tgt   (btc_tgt),
        .all_fit   (all_fit_w),
        .src       (src_w),
        .load      (load_w),
        .load_addr (addr_w),
        .flush_q   (fq_w),
        .flush_d   (fd_w)
    );

    fetch_queue_acct #(.FETCH_W(FETCH_W), .Q_DEPTH(Q_DEPTH)) u_q (
        .clk          (clk),
        .rst          (rst),
        .flush        (fq_w),
        .icache_valid (icache_valid),
        .icache_cnt   (icache_cnt),
        .deq_cnt      (deq_cnt),
        .take         (take_w),
        .all_fit      (all_fit_w),
        .count_q      (q_count)
    );

    fetch_pc_reg #(.AW(AW), .CNT_W(CNT_W), .RESET_VEC(RESET_VEC)) u_pc (
        .clk       (clk),
        .rst       (rst),
        .load      (load_w),
        .load_addr (addr_w),
        .take      (take_w),
        .pc_q      (fetch_pc)
    );

    assign fetch_take   = take_w;
    assign flush_queue  = fq_w;
    assign flush_decode = fd_w;
    assign redirect_src = src_w;

    // R4
    late_flush_chk: assert property (@(posedge clk) disable iff (rst)
        ((mp_ex_req || mp_dp_req) && !exc_req) |-> (flush_queue && flush_decode));
    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (fetch_pc == {RESET_VEC[AW-1:2], 2'b00} && q_count == '0));
endmodule

// File: tb/fetch_addr_sel_test.sv
`timescale 1ns/1ps
module fetch_addr_sel_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        exc_req = 0, mp_ex_req = 0, mp_dp_req = 0, mp_dc_req = 0, btc_hit = 0;
    logic [31:0] exc_vec = 32'h0000_0700, mp_ex_tgt = 32'h0000_2000;
    logic [31:0] mp_dp_tgt = 32'h0000_3000, mp_dc_tgt = 32'h0000_4000, btc_tgt = 32'h0000_5000;
    logic        icache_valid = 0;
    logic [2:0]  icache_cnt = 0, deq_cnt = 0;
    logic [31:0] fetch_pc;
    logic [2:0]  fetch_take;
    logic [3:0]  q_count;
    logic        flush_queue, flush_decode;
    logic [2:0]  redirect_src;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    fetch_addr_sel uut (
        .clk(clk), .rst(rst),
        .exc_req(exc_req), .exc_vec(exc_vec),
        .mp_ex_req(mp_ex_req), .mp_ex_tgt(mp_ex_tgt),
        .mp_dp_req(mp_dp_req), .mp_dp_tgt(mp_dp_tgt),
        .mp_dc_req(mp_dc_req), .mp_dc_tgt(mp_dc_tgt),
        .btc_hit(btc_hit), .btc_tgt(btc_tgt),
        .icache_valid(icache_valid), .icache_cnt(icache_cnt), .deq_cnt(deq_cnt),
        .fetch_pc(fetch_pc), .fetch_take(fetch_take), .q_count(q_count),
        .flush_queue(flush_queue), .flush_decode(flush_decode),
        .redirect_src(redirect_src)
    );

    typedef struct packed {
        logic        exc, ex, dp, dc, btc, val;
        logic [2:0]  cnt, deq, src, take;
        logic        fq, fd;
        logic [31:0] pc;
        logic [3:0]  qc;
    } vec_t;

    // Walked from reset state: pc 0x100, queue empty
    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'd4,3'd0,3'd0,3'd4,1'b0,1'b0,32'h0000_0110,4'd4},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'd4,3'd0,3'd0,3'd4,1'b0,1'b0,32'h0000_0120,4'd8},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'd4,3'd2,3'd0,3'd0,1'b0,1'b0,32'h0000_0120,4'd6},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'd4,3'd0,3'd0,3'd2,1'b0,1'b0,32'h0000_0128,4'd8},
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,3'd4,3'd4,3'd0,3'd0,1'b0,1'b0,32'h0000_0128,4'd4},
        '{1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,3'd3,3'd0,3'd5,3'd3,1'b0,1'b0,32'h0000_5000,4'd7},
        '{1'b0,1'b0,1'b0,1'b1,1'b1,1'b1,3'd4,3'd1,3'd4,3'd0,1'b1,1'b0,32'h0000_4000,4'd0},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'd5,3'd0,3'd0,3'd4,1'b0,1'b0,32'h0000_4010,4'd4},
        '{1'b0,1'b0,1'b1,1'b1,1'b0,1'b1,3'd4,3'd0,3'd3,3'd0,1'b1,1'b1,32'h0000_3000,4'd0},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'd2,3'd0,3'd0,3'd2,1'b0,1'b0,32'h0000_3008,4'd2},
        '{1'b0,1'b1,1'b1,1'b1,1'b1,1'b1,3'd4,3'd0,3'd2,3'd0,1'b1,1'b1,32'h0000_2000,4'd0},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd4,3'd3,3'd0,3'd0,1'b0,1'b0,32'h0000_2000,4'd0},
        '{1'b1,1'b1,1'b0,1'b0,1'b0,1'b1,3'd4,3'd0,3'd1,3'd0,1'b1,1'b1,32'h0000_0700,4'd0},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'd1,3'd0,3'd0,3'd1,1'b0,1'b0,32'h0000_0704,4'd1},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,3'd0,3'd0,3'd0,3'd0,1'b0,1'b0,32'h0000_0704,4'd1},
        '{1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,3'd0,3'd1,3'd0,3'd0,1'b0,1'b0,32'h0000_0704,4'd0}
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        exc_req = 0; mp_ex_req = 0; mp_dp_req = 0; mp_dc_req = 0; btc_hit = 0;
        icache_valid = 0; icache_cnt = 0; deq_cnt = 0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        idle();
        repeat (2) @(posedge clk);
        #1;
        // R1 reset state
        check("R1", "pc", fetch_pc, 32'h0000_0100);
        check("R1", "count", {28'd0, q_count}, 32'd0);
        @(negedge clk);
        rst = 0;

        for (int i = 0; i < NV; i++) begin
            exc_req = TBL[i].exc; mp_ex_req = TBL[i].ex; mp_dp_req = TBL[i].dp;
            mp_dc_req = TBL[i].dc; btc_hit = TBL[i].btc; icache_valid = TBL[i].val;
            icache_cnt = TBL[i].cnt; deq_cnt = TBL[i].deq;
            #1;
            check("R2", "src", {29'd0, redirect_src}, {29'd0, TBL[i].src});
            check("R10", "take", {29'd0, fetch_take}, {29'd0, TBL[i].take});
            check("R3/R4/R5", "flush_queue", {31'd0, flush_queue}, {31'd0, TBL[i].fq});
            check("R3/R4/R5", "flush_decode", {31'd0, flush_decode}, {31'd0, TBL[i].fd});
            @(posedge clk);
            #1;
            // R7 R8 R9 on pc, R6 R11 on occupancy
            check("R7/R8/R9", "pc", fetch_pc, TBL[i].pc);
            check("R6/R11", "count", {28'd0, q_count}, {28'd0, TBL[i].qc});
            @(negedge clk);
        end
        idle();

        // R12: decode recovery with low address bits set
        mp_dc_tgt = 32'h0000_6003;
        mp_dc_req = 1;
        #1;
        check("R5", "flush_decode", {31'd0, flush_decode}, 32'd0);
        @(posedge clk);
        #1;
        check("R12", "pc", fetch_pc, 32'h0000_6000);
        @(negedge clk);
        idle();

        // R12: target-cache hit with unaligned target, empty queue
        btc_tgt = 32'h0000_5102;
        btc_hit = 1; icache_valid = 1; icache_cnt = 3'd2;
        #1;
        check("R7", "src", {29'd0, redirect_src}, 32'd5);
        @(posedge clk);
        #1;
        check("R12", "pc", fetch_pc, 32'h0000_5100);
        check("R11", "count", {28'd0, q_count}, 32'd2);
        @(negedge clk);
        idle();

        // R8: hit ignored when no fetch is valid
        btc_hit = 1;
        #1;
        check("R8", "src", {29'd0, redirect_src}, 32'd0);
        @(posedge clk);
        #1;
        check("R8", "pc", fetch_pc, 32'h0000_5100);
        @(negedge clk);
        idle();

        // R1: reset in mid-run
        icache_valid = 1; icache_cnt = 3'd4;
        @(posedge clk);
        @(negedge clk);
        rst = 1;
        @(posedge clk);
        #1;
        check("R1", "pc", fetch_pc, 32'h0000_0100);
        check("R1", "count", {28'd0, q_count}, 32'd0);
        @(negedge clk);
        rst = 0;
        idle();
        @(posedge clk);
        #1;
        finish_run();
    end
endmodule